// File: doc/BRIEF.md
# Delay-Slot Branch and Exception Sequencer

This block sequences the fetch program counter of a simple in-order pipeline that has one architectural branch delay slot. The decode stage reports, for each instruction that leaves it, whether the instruction is a branch or jump. For a branch it also reports whether the branch is taken, its target, and whether it is the "likely" kind. The block always lets the following instruction (the delay slot) execute, and it applies the redirect only once that slot instruction has left decode. For a likely branch that is not taken, it raises a nullify signal while the slot instruction sits in decode, so the pipeline can turn that instruction into a no-op.

The block also captures exceptions. Each exception request carries the address of the faulting instruction in decode. If that instruction is a delay slot, the branch and the slot count as one unit: the saved exception PC points at the branch (the faulting address minus 4), the branch-delay flag is set, and the pending redirect is dropped. Whether an instruction counts as a delay slot depends only on what executed just before it at run time. If a second branch sits in a delay slot, its redirect is ignored and a one-cycle error pulse is raised. Branch conditions, the register file and the datapaths are outside this block.

Top module: `dslot_seq_ctrl`

## Requirements
- R1: After reset, `fetch_pc_o` equals the RESET_VEC parameter, `epc_o` is 0, `bd_o` is 0, `nest_err_o` is 0, and no delay slot is pending, so `nullify_o` is 0.
- R2: Each cycle with `dec_valid_i`=1, `stall_i`=0 and no redirect or exception advances `fetch_pc_o` by 4 on the next edge. A cycle with `dec_valid_i`=0 leaves it unchanged.
- R3: While `stall_i`=1 and no exception is taken, `fetch_pc_o` and the pending delay-slot state hold. A branch whose slot is stalled still redirects once the slot advances.
- R4: When a taken branch leaves decode, the next `fetch_pc_o` is the branch's successor (the slot). When the following instruction (the slot) leaves decode, `fetch_pc_o` becomes the branch target.
- R5: A branch that is not taken causes no redirect. The flow continues by +4 through the slot and beyond.
- R6: `nullify_o` is 1 exactly while `dec_valid_i`=1 and the instruction in decode is the delay slot of a likely branch that was not taken. It stays 0 for the slot of a taken likely branch and for the slot of an ordinary not-taken branch.
- R7: An exception taken outside a delay slot loads `epc_o` with `exc_pc_i` and clears `bd_o`. On the next edge `fetch_pc_o` becomes the EXC_VEC parameter.
- R8: An exception taken in a delay slot loads `epc_o` with `exc_pc_i` minus 4 and sets `bd_o`. The pending branch redirect is discarded, so sequential flow from EXC_VEC follows.
- R9: Delay-slot status is dynamic. The instruction reached at a branch target after the slot has retired is not a slot, so an exception on it gives `bd_o`=0.
- R10: A branch that leaves decode while it is itself in a delay slot has its redirect ignored, does not open a new slot, and raises `nest_err_o` for exactly one cycle after that edge.
- R11: An exception request made while `nullify_o`=1 is ignored. `epc_o`, `bd_o` and the sequential advance of `fetch_pc_o` are unaffected.
- R12: An exception request is taken even while `stall_i`=1.
- R13: Bits [1:0] of `dec_target_i` are ignored, so every redirect lands on a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Holds the fetch PC and slot state |
| dec_valid_i | input | 1 | Decode stage holds a real instruction |
| dec_is_branch_i | input | 1 | Instruction in decode is a branch or jump |
| dec_taken_i | input | 1 | Branch condition resolved as taken |
| dec_likely_i | input | 1 | Branch is the likely (slot-nullifying) kind |
| dec_target_i | input | 32 | Branch target address |
| exc_req_i | input | 1 | Instruction in decode raises an exception |
| exc_pc_i | input | 32 | Address of the faulting instruction |
| fetch_pc_o | output | 32 | Next fetch address |
| nullify_o | output | 1 | Turn the delay-slot instruction in decode into a no-op |
| epc_o | output | 32 | Captured exception return address |
| bd_o | output | 1 | Last exception was taken in a delay slot |
| nest_err_o | output | 1 | One-cycle pulse: branch found in a delay slot |

## Verification
The bench builds the block with RESET_VEC = 0x4000 and EXC_VEC = 0x200. These two vectors are far apart and neither is zero, so a PC that came from reset, from an exception or from a redirect can be told apart at a glance. With EXC_VEC low, branch targets and faulting addresses can be chosen so that the "minus 4" delay-slot adjustment of the exception PC is easy to see. A random phase mixes stalls, bubbles, likely branches, nested branches and exceptions, including exceptions on stalled and nullified slots, against a queue-based reference model.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int PC_W       = 32;
  localparam int STEP_BYTES = 4;

  typedef logic [PC_W-1:0] pc_t;

  // sequential successor of an instruction address
  function automatic pc_t pc_next_seq(pc_t pc);
    return pc + pc_t'(STEP_BYTES);
  endfunction

  // force word alignment of a redirect address
  function automatic pc_t pc_word(pc_t a);
    return a & ~pc_t'(STEP_BYTES - 1);
  endfunction

  // exception return address: the branch when the fault sits in its slot
  function automatic pc_t epc_select(pc_t fault_pc, logic in_slot);
    return in_slot ? (fault_pc - pc_t'(STEP_BYTES)) : fault_pc;
  endfunction
endpackage

// File: rtl/dslot_slot_track.sv
module dslot_slot_track
  import dslot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic br_i,
  input  logic taken_i,
  input  logic likely_i,
  input  pc_t  target_i,
  input  logic exc_take_i,
  output logic in_slot_o,
  output logic redirect_o,
  output pc_t  redirect_pc_o,
  output logic kill_o,
  output logic nest_err_o
);
  logic in_slot_q, pend_q, kill_q, err_q;
  pc_t  tgt_q;

  // named internal events
  logic br_first, br_nested, slot_retire;
  assign br_first    = adv_i & br_i & ~in_slot_q;
  assign br_nested   = adv_i & br_i & in_slot_q;
  assign slot_retire = adv_i & in_slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_slot_q <= 1'b0;
      pend_q    <= 1'b0;
      kill_q    <= 1'b0;
      tgt_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= br_nested & ~exc_take_i;
      if (exc_take_i) begin
        in_slot_q <= 1'b0;
        pend_q    <= 1'b0;
        kill_q    <= 1'b0;
      end else if (slot_retire) begin
        in_slot_q <= 1'b0;
        pend_q    <= 1'b0;
        kill_q    <= 1'b0;
      end else if (br_first) begin
        in_slot_q <= 1'b1;
        pend_q    <= taken_i;
        kill_q    <= likely_i & ~taken_i;
        tgt_q     <= pc_word(target_i);
      end
    end
  end

  assign in_slot_o     = in_slot_q;
  assign redirect_o    = slot_retire & pend_q & ~exc_take_i;
  assign redirect_pc_o = tgt_q;
  assign kill_o        = in_slot_q & kill_q;
  assign nest_err_o    = err_q;

  assert_nested_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_nested && !exc_take_i) |=> (nest_err_o && !in_slot_q));
  assert_slot_one_instr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_retire && !exc_take_i) |=> !in_slot_q);
  assert_exc_drops_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_i |=> (!in_slot_q && !pend_q));
  assert_stall_holds_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !exc_take_i) |=> ($stable(in_slot_q) && $stable(pend_q)));
  assert_kill_inside_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q |-> in_slot_q);
endmodule

// File: rtl/dslot_fetch_pc.sv
module dslot_fetch_pc
  import dslot_pkg::*;
#(
  parameter pc_t RESET_VEC = 32'h0000_0000,
  parameter pc_t EXC_VEC   = 32'h0000_0100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic exc_take_i,
  input  logic redirect_i,
  input  pc_t  redirect_pc_i,
  output pc_t  pc_o
);
  pc_t pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= pc_word(RESET_VEC);
    else if (exc_take_i) pc_q <= pc_word(EXC_VEC);
    else if (redirect_i) pc_q <= redirect_pc_i;
    else if (adv_i)      pc_q <= pc_next_seq(pc_q);
  end

  assign pc_o = pc_q;

  assert_exc_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_i |=> (pc_q == pc_word(EXC_VEC)));
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !exc_take_i && !redirect_i) |=> (pc_q == $past(pc_q) + 32'd4));
  assert_stall_holds_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !exc_take_i) |=> $stable(pc_q));
  assert_word_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);
endmodule

// File: rtl/dslot_exc_capture.sv
module dslot_exc_capture
  import dslot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_take_i,
  input  logic in_slot_i,
  input  pc_t  fault_pc_i,
  output pc_t  epc_o,
  output logic bd_o
);
  pc_t  epc_q;
  logic bd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q <= '0;
      bd_q  <= 1'b0;
    end else if (exc_take_i) begin
      epc_q <= epc_select(fault_pc_i, in_slot_i);
      bd_q  <= in_slot_i;
    end
  end

  assign epc_o = epc_q;
  assign bd_o  = bd_q;

  assert_slot_epc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take_i && in_slot_i) |=> (bd_q && epc_q == $past(fault_pc_i) - 32'd4));
  assert_plain_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take_i && !in_slot_i) |=> (!bd_q && epc_q == $past(fault_pc_i)));
  assert_epc_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take_i |=> ($stable(epc_q) && $stable(bd_q)));
endmodule

// File: rtl/dslot_seq_ctrl.sv
module dslot_seq_ctrl
  import dslot_pkg::*;
#(
  parameter pc_t RESET_VEC = 32'h0000_0000,
  parameter pc_t EXC_VEC   = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall_i,
  input  logic        dec_valid_i,
  input  logic        dec_is_branch_i,
  input  logic        dec_taken_i,
  input  logic        dec_likely_i,
  input  logic [31:0] dec_target_i,
  input  logic        exc_req_i,
  input  logic [31:0] exc_pc_i,
  output logic [31:0] fetch_pc_o,
  output logic        nullify_o,
  output logic [31:0] epc_o,
  output logic        bd_o,
  output logic        nest_err_o
);
  // named internal events
  logic adv, exc_take, in_slot, redirect, kill;
  pc_t  redirect_pc;

  assign adv       = dec_valid_i & ~stall_i;
  assign nullify_o = kill & dec_valid_i;
  assign exc_take  = exc_req_i & ~nullify_o;

  dslot_slot_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv_i         (adv),
    .br_i          (dec_is_branch_i),
    .taken_i       (dec_taken_i),
    .likely_i      (dec_likely_i),
    .target_i      (dec_target_i),
    .exc_take_i    (exc_take),
    .in_slot_o     (in_slot),
    .redirect_o    (redirect),
    .redirect_pc_o (redirect_pc),
    .kill_o        (kill),
    .nest_err_o    (nest_err_o)
  );

  dslot_fetch_pc #(
    .RESET_VEC (RESET_VEC),
    .EXC_VEC   (EXC_VEC)
  ) u_pc (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv_i         (adv),
    .exc_take_i    (exc_take),
    .redirect_i    (redirect),
    .redirect_pc_i (redirect_pc),
    .pc_o          (fetch_pc_o)
  );

  dslot_exc_capture u_exc (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_take_i (exc_take),
    .in_slot_i  (in_slot),
    .fault_pc_i (exc_pc_i),
    .epc_o      (epc_o),
    .bd_o       (bd_o)
  );

  assert_stall_exc_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && stall_i && !nullify_o) |=> (fetch_pc_o == pc_word(EXC_VEC)));
  assert_nullified_exc_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && nullify_o) |=> ($stable(epc_o) && $stable(bd_o)));
endmodule

// File: tb/dslot_seq_ctrl_bench.sv
module dslot_seq_ctrl_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_V      = 32'h0000_4000;
  localparam logic [31:0] EXC_V      = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i, dec_valid_i, dec_is_branch_i, dec_taken_i, dec_likely_i, exc_req_i;
  logic [31:0] dec_target_i, exc_pc_i;
  logic [31:0] fetch_pc_o, epc_o;
  logic        nullify_o, bd_o, nest_err_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dslot_seq_ctrl #(.RESET_VEC(RST_V), .EXC_VEC(EXC_V)) u_dslot_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .dec_valid_i(dec_valid_i),
    .dec_is_branch_i(dec_is_branch_i), .dec_taken_i(dec_taken_i),
    .dec_likely_i(dec_likely_i), .dec_target_i(dec_target_i),
    .exc_req_i(exc_req_i), .exc_pc_i(exc_pc_i), .fetch_pc_o(fetch_pc_o),
    .nullify_o(nullify_o), .epc_o(epc_o), .bd_o(bd_o), .nest_err_o(nest_err_o)
  );

  // behavioural reference: slot flag plus a queue of pending redirects
  logic [31:0] m_pc, m_epc;
  logic        m_bd, m_err, m_slot, m_kill;
  logic [31:0] redir_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_null();
    return m_slot && m_kill && dec_valid_i;
  endfunction

  task automatic model_step();
    logic take, adv;
    take = exc_req_i && !m_null();
    adv  = dec_valid_i && !stall_i;
    m_err = 1'b0;
    if (take) begin
      m_epc = m_slot ? exc_pc_i - 4 : exc_pc_i;
      m_bd  = m_slot;
      m_pc  = EXC_V;
      m_slot = 1'b0; m_kill = 1'b0;
      redir_q.delete();
    end else if (adv) begin
      if (m_slot) begin
        m_err = dec_is_branch_i;
        if (redir_q.size() > 0) m_pc = redir_q.pop_front();
        else m_pc = m_pc + 4;
        m_slot = 1'b0; m_kill = 1'b0;
      end else begin
        m_pc = m_pc + 4;
        if (dec_is_branch_i) begin
          m_slot = 1'b1;
          m_kill = dec_likely_i && !dec_taken_i;
          if (dec_taken_i) redir_q.push_back({dec_target_i[31:2], 2'b00});
        end
      end
    end
  endtask

  task automatic drive(bit v, bit st, bit br, bit tk, bit lk, logic [31:0] tgt,
                       bit ex, logic [31:0] xpc);
    dec_valid_i = v; stall_i = st; dec_is_branch_i = br; dec_taken_i = tk;
    dec_likely_i = lk; dec_target_i = tgt; exc_req_i = ex; exc_pc_i = xpc;
  endtask

  task automatic plain();
    drive(1, 0, 0, 0, 0, 32'h0, 0, 32'h0);
  endtask

  // one clock: combinational compare, edge, model update, registered compare
  task automatic tick();
    #1;
    chk("MODEL nullify", {31'b0, nullify_o}, {31'b0, m_null()});
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("MODEL fetch_pc", fetch_pc_o, m_pc);
    chk("MODEL epc", epc_o, m_epc);
    chk("MODEL bd", {31'b0, bd_o}, {31'b0, m_bd});
    chk("MODEL nest_err", {31'b0, nest_err_o}, {31'b0, m_err});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 32'h0, 0, 32'h0);
    m_pc = RST_V; m_epc = 0; m_bd = 0; m_err = 0; m_slot = 0; m_kill = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 fetch_pc", fetch_pc_o, RST_V);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 bd", {31'b0, bd_o}, 32'h0);
    chk("R1 nullify", {31'b0, nullify_o}, 32'h0);
    chk("R1 nest_err", {31'b0, nest_err_o}, 32'h0);

    plain(); tick(); tick();
    chk("R2 sequential +4", fetch_pc_o, 32'h4008);
    drive(0, 0, 0, 0, 0, 32'h0, 0, 32'h0); tick();
    chk("R2 bubble holds", fetch_pc_o, 32'h4008);
    drive(1, 1, 0, 0, 0, 32'h0, 0, 32'h0); tick();
    chk("R3 stall holds", fetch_pc_o, 32'h4008);

    drive(1, 0, 1, 1, 0, 32'h5003, 0, 32'h0); tick();
    chk("R4 slot fetched", fetch_pc_o, 32'h400C);
    drive(1, 1, 0, 0, 0, 32'h0, 0, 32'h0); tick(); tick();
    chk("R3 stalled slot", fetch_pc_o, 32'h400C);
    plain(); tick();
    chk("R4 R13 redirect aligned", fetch_pc_o, 32'h5000);

    drive(1, 0, 0, 0, 0, 32'h0, 1, 32'h5000); tick();
    chk("R7 epc", epc_o, 32'h5000);
    chk("R9 bd clear at target", {31'b0, bd_o}, 32'h0);
    chk("R7 vector", fetch_pc_o, EXC_V);

    drive(1, 0, 1, 0, 0, 32'h900, 0, 32'h0); tick();
    plain(); #1;
    chk("R6 plain not-taken no nullify", {31'b0, nullify_o}, 32'h0);
    tick();
    chk("R5 not taken", fetch_pc_o, 32'h208);

    drive(1, 0, 1, 0, 1, 32'h900, 0, 32'h0); tick();
    drive(1, 0, 0, 0, 0, 32'h0, 1, 32'h20C); #1;
    chk("R6 likely not-taken nullify", {31'b0, nullify_o}, 32'h1);
    tick();
    chk("R11 pc continues", fetch_pc_o, 32'h210);
    chk("R11 epc kept", epc_o, 32'h5000);
    chk("R11 bd kept", {31'b0, bd_o}, 32'h0);

    drive(1, 0, 1, 1, 1, 32'h300, 0, 32'h0); tick();
    plain(); #1;
    chk("R6 likely taken no nullify", {31'b0, nullify_o}, 32'h0);
    tick();
    chk("R4 likely taken redirect", fetch_pc_o, 32'h300);

    drive(1, 0, 1, 1, 0, 32'h400, 0, 32'h0); tick();
    drive(1, 0, 0, 0, 0, 32'h0, 1, 32'h304); tick();
    chk("R8 epc at branch", epc_o, 32'h300);
    chk("R8 bd set", {31'b0, bd_o}, 32'h1);
    chk("R8 vector", fetch_pc_o, EXC_V);
    plain(); tick();
    chk("R8 redirect dropped", fetch_pc_o, 32'h204);

    drive(1, 0, 1, 1, 0, 32'h500, 0, 32'h0); tick();
    drive(1, 0, 1, 1, 0, 32'h600, 0, 32'h0); tick();
    chk("R10 first redirect", fetch_pc_o, 32'h500);
    chk("R10 error pulse", {31'b0, nest_err_o}, 32'h1);
    plain(); tick();
    chk("R10 pulse one cycle", {31'b0, nest_err_o}, 32'h0);
    tick();
    chk("R10 second ignored", fetch_pc_o, 32'h508);

    drive(1, 1, 0, 0, 0, 32'h0, 1, 32'h508); tick();
    chk("R12 exc in stall epc", epc_o, 32'h508);
    chk("R12 exc in stall pc", fetch_pc_o, EXC_V);

    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 5) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0,
            ($urandom % 2) == 0, ($urandom % 3) == 0, $urandom & 32'h0000_FFFF,
            ($urandom % 20) == 0, $urandom & 32'h0000_FFFC);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule